// File: doc/BRIEF.md
# Serial Flash Boot Image Fetcher

This block is the boot master for a serial configuration flash. A rising edge on `init_n` latches two straps. One strap selects single-image or dual-image operation. The other selects the read command. The block then drives chip select, serial clock and MOSI to read a fixed-length image out of the flash. Every image byte goes out on a byte stream with a one-cycle valid strobe. A downstream loader consumes the stream and checks the CRC itself.

In single-image mode the flash holds one contiguous image that starts at address zero. In dual-image mode each boot begins with the primary image at `primary_addr`. If the loader reports a CRC error during that attempt, the block closes the transfer and waits at least one serial clock period. It then reads the fallback image from `fallback_addr`, which sits at the bottom of the flash. A CRC error on the last image tried is terminal. The block raises `boot_fail` and starts no further reads until the next init edge.

Top module: `spi_boot_fetch`

## Requirements
- R1: The command byte is 0x03 when `fast_n` was high at the init rising edge and 0x0B when it was low. It is followed at once by a 24-bit address, most significant bit first. Strap changes after that edge have no effect on the boot in progress.
- R2: With command 0x0B one dummy byte follows the address, so data starts at serial bit 41. With 0x03 data starts at bit 33. Each data byte arrives most significant bit first.
- R3: The serial clock idles low while chip select (`cs_n`, active low) is high. MOSI changes only on a serial clock falling edge. MISO is sampled on the rising edge.
- R4: In single-image mode (`dual_strap` low at init) the read address is 0, whatever the value of `primary_addr`.
- R5: In dual-image mode the first attempt reads from `primary_addr` with `image_fallback` low.
- R6: A CRC error during the primary attempt aborts it. Chip select stays high for at least 2*SCLK_HALF clock cycles. A new read then starts at `fallback_addr` with `image_fallback` high.
- R7: A CRC error during the fallback attempt, or during the only attempt in single-image mode, raises `boot_fail`. Chip select then stays high and no further read starts.
- R8: An attempt delivers exactly IMG_BYTES bytes, then raises chip select. `boot_done` rises if no CRC error arrived before the cycle after the last byte.
- R9: A CRC error in the same cycle as the last byte strobe counts as a failed attempt.
- R10: `byte_valid` is only ever high while chip select is low. No byte from an aborted attempt is presented after the abort.
- R11: After reset `cs_n`=1, `sclk`=0, and `byte_valid`, `boot_done` and `boot_fail` are 0. Nothing starts without an init rising edge.
- R12: An init rising edge after a finished or failed boot clears both status flags and starts a fresh boot from the primary (or only) image, using the newly latched straps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_n | input | 1 | Init line; its rising edge latches straps and starts a boot |
| dual_strap | input | 1 | 1 = dual-image mode, 0 = single-image mode |
| fast_n | input | 1 | 1 = standard read 0x03, 0 = fast read 0x0B |
| primary_addr | input | 24 | Start address of the primary image |
| fallback_addr | input | 24 | Start address of the fallback image |
| crc_err | input | 1 | CRC failure reported by the consumer |
| miso | input | 1 | Serial data from flash |
| cs_n | output | 1 | Flash chip select, active low |
| sclk | output | 1 | Serial clock to flash |
| mosi | output | 1 | Serial command/address to flash |
| byte_data | output | 8 | Image byte |
| byte_valid | output | 1 | One-cycle strobe for `byte_data` |
| image_fallback | output | 1 | Current attempt reads the fallback image |
| boot_done | output | 1 | Image read completed without CRC error |
| boot_fail | output | 1 | Terminal CRC failure |

## Verification
Two things can land in the same cycle: the strobe of the final image byte, which ends the attempt, and a CRC error from the consumer, which aborts it. The bench creates this collision by raising `crc_err` in exactly the cycle in which the last byte of an image is valid. It does this for the primary image, for the fallback image and in single-image mode. The result counts as correct only if the error wins in every case. A primary collision must produce a second flash session at the fallback address. A fallback or single-image collision must produce `boot_fail` with no `boot_done` and no further session. The same sweep also injects the error mid-image, where there is no collision, to show the two paths stay distinct.

// File: rtl/spi_boot_pkg.sv
package spi_boot_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_XFER,
    ST_END,
    ST_GAP,
    ST_DONE,
    ST_FAIL
  } boot_st_e;

  localparam logic [7:0] CMD_STD  = 8'h03;
  localparam logic [7:0] CMD_FAST = 8'h0B;
  localparam int         HDR_W    = 40;

  // command byte chosen by the latched read strap (high = standard)
  function automatic logic [7:0] read_cmd(input logic fast_n);
    return fast_n ? CMD_STD : CMD_FAST;
  endfunction

  // serial bits preceding the first data bit
  function automatic logic [5:0] header_bits(input logic fast_n);
    return fast_n ? 6'd32 : 6'd40;
  endfunction

  // outgoing header: command, 24-bit address, dummy byte
  function automatic logic [HDR_W-1:0] header_word(input logic fast_n,
                                                   input logic [23:0] addr);
    return {read_cmd(fast_n), addr, 8'h00};
  endfunction

endpackage

// File: rtl/spi_boot_sclk.sv
module spi_boot_sclk #(
  parameter int SCLK_HALF = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic rise_ev,
  output logic fall_ev
);
  localparam int CW = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(SCLK_HALF - 1);

  logic [CW-1:0] div_cnt;
  logic          toggle_now;

  assign toggle_now = run && (div_cnt == CNT_LAST);
  assign rise_ev    = toggle_now && !sclk;
  assign fall_ev    = toggle_now && sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      sclk    <= 1'b0;
    end else if (!run) begin
      div_cnt <= '0;
      sclk    <= 1'b0;
    end else if (toggle_now) begin
      div_cnt <= '0;
      sclk    <= ~sclk;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spi_boot_shift.sv
module spi_boot_shift
  import spi_boot_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [HDR_W-1:0] hdr_in,
  input  logic [5:0]       hdr_bits,
  input  logic             rise_ev,
  input  logic             fall_ev,
  input  logic             miso,
  output logic             mosi,
  output logic [7:0]       byte_data,
  output logic             byte_stb
);
  logic [HDR_W-1:0] out_sr;
  logic [6:0]       in_sr;
  logic [CNT_W-1:0] bit_cnt;
  logic [5:0]       hdr_q;
  logic [CNT_W-1:0] data_idx;
  logic             in_data;
  logic             byte_end;

  assign mosi     = out_sr[HDR_W-1];
  assign in_data  = bit_cnt >= CNT_W'(hdr_q);
  assign data_idx = bit_cnt - CNT_W'(hdr_q);
  assign byte_end = in_data && (data_idx[2:0] == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_sr    <= '0;
      in_sr     <= '0;
      bit_cnt   <= '0;
      hdr_q     <= 6'd32;
      byte_data <= '0;
      byte_stb  <= 1'b0;
    end else begin
      byte_stb <= 1'b0;
      if (load) begin
        out_sr  <= hdr_in;
        bit_cnt <= '0;
        hdr_q   <= hdr_bits;
      end else begin
        if (fall_ev) out_sr <= {out_sr[HDR_W-2:0], 1'b0};
        if (rise_ev) begin
          bit_cnt <= bit_cnt + 1'b1;
          if (in_data) begin
            in_sr <= {in_sr[5:0], miso};
            if (byte_end) begin
              byte_data <= {in_sr, miso};
              byte_stb  <= 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_boot_seq.sv
module spi_boot_seq
  import spi_boot_pkg::*;
#(
  parameter int IMG_BYTES = 16,
  parameter int GAP_CYC   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_n,
  input  logic             dual_strap,
  input  logic             fast_n,
  input  logic [23:0]      primary_addr,
  input  logic [23:0]      fallback_addr,
  input  logic             crc_err,
  input  logic             byte_stb,
  output logic             load,
  output logic [HDR_W-1:0] hdr_word,
  output logic [5:0]       hdr_bits,
  output logic             run,
  output logic             on_fallback,
  output logic             boot_done,
  output logic             boot_fail,
  output logic             init_rise,
  output logic             attempt_abort
);
  localparam int BC_W = $clog2(IMG_BYTES + 1);
  localparam int GW   = $clog2(GAP_CYC + 1);
  localparam logic [BC_W-1:0] BYTE_LAST = BC_W'(IMG_BYTES - 1);
  localparam logic [GW-1:0]   GAP_LAST  = GW'(GAP_CYC - 1);

  boot_st_e        state;
  logic            init_q, dual_q, fast_q;
  logic [BC_W-1:0] byte_cnt;
  logic [GW-1:0]   gap_cnt;
  logic            gap_done;
  logic            use_fast;
  logic [23:0]     use_addr;

  assign init_rise     = init_n && !init_q;
  assign gap_done      = (state == ST_GAP) && (gap_cnt == GAP_LAST);
  assign attempt_abort = crc_err && !init_rise &&
                         ((state == ST_XFER) || (state == ST_END));
  assign load          = init_rise || gap_done;

  always_comb begin
    if (init_rise) begin
      use_fast = fast_n;
      use_addr = dual_strap ? primary_addr : 24'h000000;
    end else begin
      use_fast = fast_q;
      use_addr = fallback_addr;
    end
  end

  assign hdr_word  = header_word(use_fast, use_addr);
  assign hdr_bits  = header_bits(use_fast);
  assign run       = (state == ST_XFER);
  assign boot_done = (state == ST_DONE);
  assign boot_fail = (state == ST_FAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      init_q      <= 1'b1;
      dual_q      <= 1'b0;
      fast_q      <= 1'b1;
      on_fallback <= 1'b0;
      byte_cnt    <= '0;
      gap_cnt     <= '0;
    end else begin
      init_q <= init_n;
      if (init_rise) begin
        dual_q      <= dual_strap;
        fast_q      <= fast_n;
        on_fallback <= 1'b0;
        byte_cnt    <= '0;
        state       <= ST_XFER;
      end else if (attempt_abort) begin
        gap_cnt <= '0;
        state   <= (dual_q && !on_fallback) ? ST_GAP : ST_FAIL;
      end else begin
        case (state)
          ST_XFER: if (byte_stb) begin
            if (byte_cnt == BYTE_LAST) state <= ST_END;
            else byte_cnt <= byte_cnt + 1'b1;
          end
          ST_END:  state <= ST_DONE;
          ST_GAP:  if (gap_done) begin
            on_fallback <= 1'b1;
            byte_cnt    <= '0;
            state       <= ST_XFER;
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
          default: state <= state;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_boot_fetch.sv
module spi_boot_fetch
  import spi_boot_pkg::*;
#(
  parameter int IMG_BYTES = 16,
  parameter int SCLK_HALF = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init_n,
  input  logic        dual_strap,
  input  logic        fast_n,
  input  logic [23:0] primary_addr,
  input  logic [23:0] fallback_addr,
  input  logic        crc_err,
  input  logic        miso,
  output logic        cs_n,
  output logic        sclk,
  output logic        mosi,
  output logic [7:0]  byte_data,
  output logic        byte_valid,
  output logic        image_fallback,
  output logic        boot_done,
  output logic        boot_fail
);
  localparam int GAP_CYC = 2 * SCLK_HALF;
  localparam int CNT_W   = $clog2(HDR_W + 8 * IMG_BYTES + 1);

  logic             load_w, run_w, rise_w, fall_w, stb_w;
  logic             init_rise_w, abort_w;
  logic [HDR_W-1:0] hdr_w;
  logic [5:0]       hbits_w;

  spi_boot_seq #(.IMG_BYTES(IMG_BYTES), .GAP_CYC(GAP_CYC)) seq_i (
    .clk(clk), .rst_n(rst_n), .init_n(init_n), .dual_strap(dual_strap),
    .fast_n(fast_n), .primary_addr(primary_addr), .fallback_addr(fallback_addr),
    .crc_err(crc_err), .byte_stb(stb_w), .load(load_w), .hdr_word(hdr_w),
    .hdr_bits(hbits_w), .run(run_w), .on_fallback(image_fallback),
    .boot_done(boot_done), .boot_fail(boot_fail), .init_rise(init_rise_w),
    .attempt_abort(abort_w)
  );

  spi_boot_sclk #(.SCLK_HALF(SCLK_HALF)) sclk_i (
    .clk(clk), .rst_n(rst_n), .run(run_w), .sclk(sclk),
    .rise_ev(rise_w), .fall_ev(fall_w)
  );

  spi_boot_shift #(.CNT_W(CNT_W)) shift_i (
    .clk(clk), .rst_n(rst_n), .load(load_w), .hdr_in(hdr_w),
    .hdr_bits(hbits_w), .rise_ev(rise_w), .fall_ev(fall_w), .miso(miso),
    .mosi(mosi), .byte_data(byte_data), .byte_stb(stb_w)
  );

  assign cs_n       = !run_w;
  assign byte_valid = stb_w && run_w;
endmodule

// File: rtl/spi_boot_fetch_chk.sv
module spi_boot_fetch_chk #(
  parameter int GAP_CYC = 2
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sclk,
  input logic mosi,
  input logic byte_valid,
  input logic crc_err,
  input logic boot_fail,
  input logic image_fallback,
  input logic init_rise
);
  logic [15:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_cnt <= '0;
    else if (!cs_n) hi_cnt <= '0;
    else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 1'b1;
  end

  assert_sclk_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n)) |-> !sclk);

  assert_mosi_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n) && !$past(init_rise) && !$stable(mosi)) |-> $fell(sclk));

  assert_stream_in_xfer_R10: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> !cs_n);

  assert_fail_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(boot_fail) |-> $past(crc_err));

  assert_fail_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    boot_fail |-> cs_n);

  assert_fallback_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_n) && image_fallback) |-> (hi_cnt >= 16'(GAP_CYC)));
endmodule

bind spi_boot_fetch spi_boot_fetch_chk #(.GAP_CYC(2 * SCLK_HALF)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
  .byte_valid(byte_valid), .crc_err(crc_err), .boot_fail(boot_fail),
  .image_fallback(image_fallback), .init_rise(init_rise_w)
);

// File: tb/spi_boot_fetch_tb_top.sv
module spi_boot_fetch_tb_top;
  localparam int IMG = 16;

  logic clk = 1'b0, rst_n = 1'b0, init_n = 1'b1, dual_strap = 1'b0, fast_n = 1'b1;
  logic [23:0] primary_addr = '0, fallback_addr = '0;
  logic crc_err = 1'b0, miso = 1'b0;
  logic cs_n, sclk, mosi, byte_valid, image_fallback, boot_done, boot_fail;
  logic [7:0] byte_data;

  int errors = 0, checks = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  spi_boot_fetch #(.IMG_BYTES(IMG), .SCLK_HALF(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .init_n(init_n), .dual_strap(dual_strap),
    .fast_n(fast_n), .primary_addr(primary_addr), .fallback_addr(fallback_addr),
    .crc_err(crc_err), .miso(miso), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .byte_data(byte_data), .byte_valid(byte_valid),
    .image_fallback(image_fallback), .boot_done(boot_done), .boot_fail(boot_fail)
  );

  function automatic logic [7:0] fbyte(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
  endfunction

  // flash model
  int          f_bits = 0;
  logic [7:0]  f_op = '0;
  logic [23:0] f_addr = '0;
  int          sess_n = 0;
  logic [7:0]  sess_op [0:63];
  logic [23:0] sess_addr [0:63];

  always @(negedge cs_n or posedge sclk) begin
    if (!sclk) begin
      f_bits = 0; f_op = '0; f_addr = '0;
    end else if (!cs_n) begin
      f_bits = f_bits + 1;
      if (f_bits <= 8) f_op = {f_op[6:0], mosi};
      else if (f_bits <= 32) f_addr = {f_addr[22:0], mosi};
      if (f_bits == 32 && sess_n < 64) begin
        sess_op[sess_n] = f_op; sess_addr[sess_n] = f_addr; sess_n = sess_n + 1;
      end
    end
  end

  always @(negedge sclk) begin
    if (!cs_n) begin
      int hb;
      hb = (f_op == 8'h0B) ? 40 : 32;
      if (f_bits >= hb) begin
        int idx;
        logic [7:0] b;
        idx = f_bits - hb;
        b = fbyte(f_addr + 24'(idx / 8));
        miso = b[7 - (idx % 8)];
      end
    end
  end

  // port monitor
  int mosi_viol = 0, bv_viol = 0, hi_run = 0, last_gap = 0;
  logic prev_cs = 1'b1, prev_sclk = 1'b0, prev_mosi = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!cs_n && !prev_cs && mosi != prev_mosi && !(prev_sclk && !sclk)) mosi_viol++;
      if (byte_valid && cs_n) bv_viol++;
      if (cs_n) hi_run++;
      else begin
        if (prev_cs) last_gap = hi_run;
        hi_run = 0;
      end
    end
    prev_cs = cs_n; prev_sclk = sclk; prev_mosi = mosi;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_boot(input bit dual, input bit fst, input logic [23:0] pa,
                          input logic [23:0] fa, input int perr, input int ferr);
    logic [7:0] pb [0:IMG-1];
    logic [7:0] fb [0:IMG-1];
    int np, nf, base, exp_sess, bad;
    bit exp_done;
    logic [23:0] a0;
    np = 0; nf = 0;
    init_n = 1'b0; dual_strap = dual; fast_n = fst;
    primary_addr = pa; fallback_addr = fa; crc_err = 1'b0;
    repeat (3) @(negedge clk);
    base = sess_n;
    init_n = 1'b1;
    repeat (2) @(negedge clk);
    // R12: fresh start after init edge
    chk(!cs_n && !boot_fail && !boot_done && !image_fallback, "R12", "restart",
        {cs_n, boot_fail, boot_done, image_fallback}, 0);
    dual_strap = !dual; fast_n = !fst;   // R1: later strap changes ignored
    for (int cyc = 0; cyc < 3000; cyc++) begin
      @(negedge clk);
      crc_err = 1'b0;
      if (byte_valid) begin
        if (!image_fallback) begin
          if (np < IMG) pb[np] = byte_data;
          if (np == perr) crc_err = 1'b1;   // R9 when perr is the last byte
          np++;
        end else begin
          if (nf < IMG) fb[nf] = byte_data;
          if (nf == ferr) crc_err = 1'b1;
          nf++;
        end
      end
      if (boot_done || boot_fail) break;
    end
    crc_err = 1'b0;
    exp_done = (perr < 0) || (dual && ferr < 0);
    exp_sess = (perr < 0 || !dual) ? 1 : 2;
    chk(boot_done == exp_done, "R8", "boot_done", boot_done, exp_done);
    chk(boot_fail == !exp_done, "R7", "boot_fail", boot_fail, !exp_done);
    repeat (40) @(negedge clk);
    chk(sess_n - base == exp_sess, "R6", "session count", sess_n - base, exp_sess);
    chk(cs_n, "R7", "cs idle after end", cs_n, 1);
    chk(sess_op[base] == (fst ? 8'h03 : 8'h0B), "R1", "opcode",
        sess_op[base], fst ? 8'h03 : 8'h0B);
    a0 = dual ? pa : 24'h0;
    chk(sess_addr[base] == a0, dual ? "R5" : "R4", "first address", sess_addr[base], a0);
    chk(np == ((perr < 0) ? IMG : perr + 1), "R10", "primary byte count",
        np, (perr < 0) ? IMG : perr + 1);
    bad = 0;
    for (int i = 0; i < np && i < IMG; i++) if (pb[i] !== fbyte(a0 + 24'(i))) bad++;
    chk(bad == 0, "R2", "primary data", bad, 0);
    if (exp_sess == 2) begin
      chk(sess_addr[base + 1] == fa, "R6", "fallback address", sess_addr[base + 1], fa);
      chk(sess_op[base + 1] == sess_op[base], "R6", "fallback opcode",
          sess_op[base + 1], sess_op[base]);
      chk(last_gap >= 2, "R6", "cs gap", last_gap, 2);
      chk(nf == ((ferr < 0) ? IMG : ferr + 1), "R8", "fallback byte count",
          nf, (ferr < 0) ? IMG : ferr + 1);
      bad = 0;
      for (int i = 0; i < nf && i < IMG; i++) if (fb[i] !== fbyte(fa + 24'(i))) bad++;
      chk(bad == 0, "R2", "fallback data", bad, 0);
    end else begin
      chk(nf == 0, "R7", "no fallback bytes", nf, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    // R11: reset state, no start without init edge
    chk(cs_n && !sclk && !byte_valid && !boot_done && !boot_fail && sess_n == 0,
        "R11", "reset state", {cs_n, sclk, byte_valid, boot_done, boot_fail}, 5'b10000);
    for (int d = 0; d < 2; d++) begin
      for (int f = 0; f < 2; f++) begin
        for (int e = 0; e < 3; e++) begin
          int perr;
          perr = (e == 0) ? -1 : ((e == 1) ? 5 : IMG - 1);
          if (d == 0 || perr < 0) begin
            run_boot(d[0], f[0], 24'h012340, 24'h000100, perr, -1);
          end else begin
            run_boot(1'b1, f[0], 24'h012340, 24'h000100, perr, -1);
            run_boot(1'b1, f[0], 24'h0A5F00, 24'h000100, perr, IMG - 1);
          end
        end
      end
    end
    chk(mosi_viol == 0, "R3", "mosi change off falling edge", mosi_viol, 0);
    chk(bv_viol == 0, "R10", "byte_valid with cs high", bv_viol, 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule